// File: doc/BRIEF.md
# Four-Pin Register-Programmed GPIO Controller

This block gives software control over four general-purpose pins through a small byte-wide register bus. The bus has an address, write data, a write strobe and a combinational read-data return. Three writable registers hold the control state: per-pin output enables, per-pin input/mode and pull-up enables, and per-pin output data. A read-only register returns the sampled pin levels.

The two control bits of a pin decide together how it is driven. With the output enable clear, the pin is released. With it set, the pin is driven in one of two styles. When the input/mode bit is clear, the pin drives both levels (push-pull). When that bit is set, the pin drives only a low level and releases for a high one (open-drain). The same input/mode bit also gates the input. A disabled input reads back as 1, so a floating pad never reaches the read path. Pull-up requests follow the pull-up enable, except while the pin actively pulls low.

Pad inputs pass through a two-flop synchronizer before they are masked and read. The pad control outputs are decoded from the registered state without further delay.

Top module: `gpio4_ctrl`

## Requirements
- R1: After reset all writable bits are 0. Every pin then has drive enable 0 and pull-up request 0. Reads return 0x00 at offsets 0, 1 and 2, and 0x0F at offset 3.
- R2: Offset 0 bits 3:0 are the output enables of pins 0..3. A pin whose output enable is 0 has drive enable 0, whatever its data and mode bits hold.
- R3: Offset 1 bits 3:0 are the per-pin input/mode bits. With output enable 1 and mode bit 0, the drive enable is 1 and the driven value equals the pin's data bit. The data bits are offset 2 bits 3:0.
- R4: With output enable 1 and mode bit 1, the driven value is 0. The drive enable is 1 only while the data bit is 0.
- R5: A pin whose mode bit is 0 reads as 1 in offset 3, whatever level is on its pad.
- R6: A pin whose mode bit is 1 reads its pad level in offset 3 once two clock edges have passed since the pad changed.
- R7: Offset 1 bits 7:4 are the pull-up enables of pins 0..3. The pull-up request of a pin equals its pull-up enable, except that it is 0 while the pin is driven with value 0.
- R8: Bits 7:4 of offsets 0, 2 and 3 read 0, and writes to those bits are ignored. Writes to offset 3 change no state.
- R9: A write is captured at the clock edge where the write strobe is high. The new value appears on the read path and on the pad outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 4 | Pin levels from the pads |
| pad_out | output | 4 | Value to drive per pin |
| pad_oe | output | 4 | Drive enable per pin |
| pad_pu | output | 4 | Pull-up request per pin |

## Verification
Register writes and pad controls are due one edge after the strobe is sampled. The bench drives each write at a falling edge and checks the outputs at the next falling edge, after the capturing rising edge. Pad input changes reach offset 3 after two rising edges. The bench changes pad_in at a falling edge and reads after exactly two rising edges, and also checks that a disabled pin stays at 1 across that window. Reads are combinational, so every readback is sampled at a falling edge with the address already stable.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
    localparam int GPIO_ADDR_W = 2;
    localparam logic [GPIO_ADDR_W-1:0] OFS_DRV_EN = 2'd0;
    localparam logic [GPIO_ADDR_W-1:0] OFS_MODE   = 2'd1;
    localparam logic [GPIO_ADDR_W-1:0] OFS_DOUT   = 2'd2;
    localparam logic [GPIO_ADDR_W-1:0] OFS_DIN    = 2'd3;
endpackage

// File: rtl/gpio4_regs.sv
module gpio4_regs #(
    parameter int NUM_PINS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] drv_en_o,
    output logic [NUM_PINS-1:0] mode_o,
    output logic [NUM_PINS-1:0] pu_en_o,
    output logic [NUM_PINS-1:0] dout_o
);
    import gpio4_pkg::*;

    typedef struct packed {
        logic [NUM_PINS-1:0] drv_en;
        logic [NUM_PINS-1:0] mode;
        logic [NUM_PINS-1:0] pu_en;
        logic [NUM_PINS-1:0] dout;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(OFS_DRV_EN)) begin
                r_d.drv_en = wr_data[NUM_PINS-1:0];
            end else if (wr_addr == ADDR_W'(OFS_MODE)) begin
                r_d.mode  = wr_data[NUM_PINS-1:0];
                r_d.pu_en = wr_data[2*NUM_PINS-1:NUM_PINS];
            end else if (wr_addr == ADDR_W'(OFS_DOUT)) begin
                r_d.dout = wr_data[NUM_PINS-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign drv_en_o = r_q.drv_en;
    assign mode_o   = r_q.mode;
    assign pu_en_o  = r_q.pu_en;
    assign dout_o   = r_q.dout;

    // R9: a write to the enable register is visible after the capturing edge
    assert_wr_drv_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFS_DRV_EN)) |=> (drv_en_o == $past(wr_data[NUM_PINS-1:0])));

    // R8: a write to the read-only offset leaves all state untouched
    assert_din_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFS_DIN)) |=> $stable(r_q));
endmodule

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] async_i,
    output logic [NUM_PINS-1:0] sync_o
);
    logic [NUM_PINS-1:0] stg_d [SYNC_STAGES];
    logic [NUM_PINS-1:0] stg_q [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stg_d[s] = async_i;
            end else begin : g_next
                always_comb stg_d[s] = stg_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign sync_o = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/gpio4_pad_ctrl.sv
module gpio4_pad_ctrl #(
    parameter int NUM_PINS = 4
) (
    input  logic [NUM_PINS-1:0] drv_en_i,
    input  logic [NUM_PINS-1:0] mode_i,
    input  logic [NUM_PINS-1:0] pu_en_i,
    input  logic [NUM_PINS-1:0] dout_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] pad_pu_o
);
    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic opdrain, drives_low;
            always_comb begin
                opdrain        = mode_i[p];
                pad_out_o[p]   = opdrain ? 1'b0 : dout_i[p];
                pad_oe_o[p]    = drv_en_i[p] & (~opdrain | ~dout_i[p]);
                drives_low     = pad_oe_o[p] & ~pad_out_o[p];
                pad_pu_o[p]    = pu_en_i[p] & ~drives_low;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio4_ctrl.sv
module gpio4_ctrl #(
    parameter int NUM_PINS    = 4,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = gpio4_pkg::GPIO_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu
);
    import gpio4_pkg::*;

    localparam int PAD_W = DATA_W - NUM_PINS;

    logic [NUM_PINS-1:0] drv_en, mode, pu_en, dout, pin_sync, din_masked;

    gpio4_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .drv_en_o(drv_en), .mode_o(mode), .pu_en_o(pu_en), .dout_o(dout)
    );

    gpio4_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(pin_sync)
    );

    gpio4_pad_ctrl #(.NUM_PINS(NUM_PINS)) u_pad (
        .drv_en_i(drv_en), .mode_i(mode), .pu_en_i(pu_en), .dout_i(dout),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu)
    );

    assign din_masked = (pin_sync & mode) | ~mode;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_DRV_EN))    bus_rdata = {{PAD_W{1'b0}}, drv_en};
        else if (bus_addr == ADDR_W'(OFS_MODE)) bus_rdata = {{(DATA_W-2*NUM_PINS){1'b0}}, pu_en, mode};
        else if (bus_addr == ADDR_W'(OFS_DOUT)) bus_rdata = {{PAD_W{1'b0}}, dout};
        else if (bus_addr == ADDR_W'(OFS_DIN))  bus_rdata = {{PAD_W{1'b0}}, din_masked};
    end

    // R2: no pin drives without its output enable
    assert_no_drive_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~drv_en) == '0);
    // R4: open-drain pins never drive a high level
    assert_opendrain_low_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & mode) == '0);
    // R7: no pull-up request while driving low
    assert_no_pu_while_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe & ~pad_out) == '0);
    // R5: disabled inputs read as 1
    assert_masked_read_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_DIN)) |-> ((bus_rdata[NUM_PINS-1:0] | mode) == '1));
    // R8: upper bits of the input-data register read 0
    assert_din_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_DIN)) |-> (bus_rdata[DATA_W-1:NUM_PINS] == '0));
endmodule

// File: tb/gpio4_ctrl_bench.sv
`timescale 1ns/1ps
module gpio4_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [3:0] pad_in = '0;
    logic [3:0] pad_out, pad_oe, pad_pu;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio4_ctrl u_gpio4_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    // independent model of the pad outputs for given register contents
    task automatic pads_chk(input string req, input logic [3:0] en, input logic [3:0] md,
                            input logic [3:0] pu, input logic [3:0] dat);
        logic [3:0] e_out, e_oe, e_pu;
        for (int p = 0; p < 4; p++) begin
            if (!en[p])       begin e_oe[p] = 1'b0; e_out[p] = md[p] ? 1'b0 : dat[p]; end
            else if (!md[p])  begin e_oe[p] = 1'b1; e_out[p] = dat[p]; end
            else              begin e_oe[p] = ~dat[p]; e_out[p] = 1'b0; end
            e_pu[p] = pu[p] && !(e_oe[p] && !e_out[p]);
        end
        chk({req, " oe"},  {4'h0, pad_oe},  {4'h0, e_oe});
        chk({req, " out"}, {4'h0, pad_out}, {4'h0, e_out});
        chk({req, " pu"},  {4'h0, pad_pu},  {4'h0, e_pu});
    endtask

    task automatic t_reset;
        chk("R1 oe", {4'h0, pad_oe}, 8'h00);
        chk("R1 pu", {4'h0, pad_pu}, 8'h00);
        rd_chk("R1 ofs0", 2'd0, 8'h00);
        rd_chk("R1 ofs1", 2'd1, 8'h00);
        rd_chk("R1 ofs2", 2'd2, 8'h00);
        rd_chk("R1 ofs3", 2'd3, 8'h0F);
    endtask

    task automatic t_reserved;
        wr(2'd0, 8'hF0);
        rd_chk("R8 ofs0 reserved", 2'd0, 8'h00);
        wr(2'd2, 8'hA5);
        rd_chk("R8 ofs2 reserved", 2'd2, 8'h05);
        wr(2'd3, 8'hFF);
        rd_chk("R8 ofs3 write ignored ofs0", 2'd0, 8'h00);
        rd_chk("R8 ofs3 write ignored ofs1", 2'd1, 8'h00);
        rd_chk("R8 ofs3 write ignored ofs2", 2'd2, 8'h05);
        rd_chk("R8 ofs3 upper zero", 2'd3, 8'h0F);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_drive_off;
        wr(2'd2, 8'h0F);
        wr(2'd1, 8'h05);
        pads_chk("R2 disabled", 4'h0, 4'h5, 4'h0, 4'hF);
    endtask

    task automatic t_push_pull;
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h09);
        wr(2'd0, 8'h0F);
        pads_chk("R3 push-pull 9", 4'hF, 4'h0, 4'h0, 4'h9);
        wr(2'd2, 8'h06);
        pads_chk("R3 push-pull 6", 4'hF, 4'h0, 4'h0, 4'h6);
        rd_chk("R9 readback ofs0", 2'd0, 8'h0F);
        rd_chk("R9 readback ofs2", 2'd2, 8'h06);
    endtask

    task automatic t_open_drain;
        wr(2'd1, 8'h0F);
        pads_chk("R4 open-drain 6", 4'hF, 4'hF, 4'h0, 4'h6);
        wr(2'd2, 8'h03);
        pads_chk("R4 open-drain 3", 4'hF, 4'hF, 4'h0, 4'h3);
    endtask

    task automatic t_pullup;
        wr(2'd1, 8'hF3);
        wr(2'd2, 8'h05);
        pads_chk("R7 mixed", 4'hF, 4'h3, 4'hF, 4'h5);
        wr(2'd0, 8'h00);
        pads_chk("R7 released", 4'h0, 4'h3, 4'hF, 4'h5);
        rd_chk("R9 readback ofs1", 2'd1, 8'hF3);
    endtask

    task automatic t_inputs;
        wr(2'd1, 8'h00);
        @(negedge clk);
        pad_in = 4'h0;
        @(negedge clk); @(negedge clk);
        rd_chk("R5 disabled low pads", 2'd3, 8'h0F);
        wr(2'd1, 8'h0A);
        @(negedge clk);
        pad_in = 4'h0;
        @(negedge clk); @(negedge clk);
        rd_chk("R6 enabled low", 2'd3, 8'h05);
        @(negedge clk);
        pad_in = 4'hF;
        @(negedge clk);
        rd_chk("R6 one edge not yet", 2'd3, 8'h05);
        @(negedge clk);
        rd_chk("R6 two edges", 2'd3, 8'h0F);
        pad_in = 4'h2;
        @(negedge clk); @(negedge clk);
        rd_chk("R6 R5 mixed", 2'd3, 8'h07);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_reserved;
        t_drive_off;
        t_push_pull;
        t_open_drain;
        t_pullup;
        t_inputs;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule